// File: doc/BRIEF.md
# Serial Port FIFO Controller

This block holds the register file, the two byte queues and the status and interrupt logic of a UART-style serial port. The bit-level shifter, parity and framing sit elsewhere. The neighbouring logic pulses `tick` once per frame time. On each tick the controller takes at most one byte from its transmit queue and offers it on the line side. It also accepts at most one byte arriving from the line, or, in loopback, the byte it has just sent.

A CPU or DMA engine reaches the block through a simple register bus with eight addresses:

| Address | Register |
|---|---|
| 0 | MODE |
| 1 | RATE |
| 2 | CTRL |
| 3 | DATA |
| 4 | STATUS |
| 5 | FIFOCTL |
| 6 | COUNT |
| 7 | LINE |

Read data is combinational. A read or write of DATA pops or pushes a queue in that cycle. `bus_dma` marks an access that comes from the DMA engine. The trigger levels can be set differently for each direction. Status bits are cleared by writing zero to them. An idle timeout raises a data-ready flag for a partly filled receive queue.

The CTRL bits are:

| Bit | Meaning |
|---|---|
| 7 | Transmit interrupt enable |
| 6 | Receive interrupt enable |
| 5 | Transmit enable |
| 4 | Receive enable |
| 3 | Error interrupt enable |

The STATUS bits are:

| Bit | Flag |
|---|---|
| 0 | READY |
| 1 | RXFULL |
| 4 | BREAK |
| 5 | TXLOW |
| 6 | TXDONE |

Top module: `serial_fifo_ctrl`

## Requirements
- R1: Each queue holds 16 bytes. A DATA write to a full transmit queue is dropped. COUNT (address 6) reports receive occupancy in bits 4:0 and transmit occupancy in bits 12:8. After reset both counts are 0 and STATUS (address 4) reads 0x60.
- R2: A byte arriving while the receive queue holds 16 bytes is discarded and sets LINE (address 7) bit 0. `irq_rx_err` then follows that bit while CTRL bit 6 or bit 3 is set. No byte is accepted while the bit is set. Writing 0 to LINE bit 0 clears it.
- R3: FIFOCTL (address 5) bits 7:6 select the receive trigger: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14. Bits 5:4 select the transmit trigger: 0 gives 8, 1 gives 4, 2 gives 2 and 3 gives 1.
- R4: When a byte is stored and the receive count reaches the trigger or more, RXFULL is set. `irq_rx_full` equals CTRL bit 6 AND (RXFULL OR READY).
- R5: On a tick with CTRL bit 5 set and a non-empty transmit queue, the oldest byte leaves the queue. It appears on `line_tx_byte` with `line_tx_valid` in the next cycle, except in loopback. If the remaining count is at or below the trigger, TXLOW is set. If the count is zero, TXDONE is set. `irq_tx_empty` equals CTRL bit 7 AND TXLOW.
- R6: A DMA write to DATA clears TXDONE. It also clears TXLOW if the new count exceeds the transmit trigger. A CPU write to DATA leaves both flags unchanged.
- R7: A DMA read of DATA that leaves the count below the receive trigger clears RXFULL. If the count becomes 0, it also clears READY. A CPU read of DATA pops the queue without touching flags. A read of an empty queue returns 0.
- R8: A STATUS write ANDs the written byte into the flags, so only bits written as 0 are cleared.
- R9: READY is set on a tick when no byte is stored on that tick or on the previous tick, and the receive count is non-zero and below the trigger.
- R10: A FIFOCTL write with bit 1 set empties the receive queue and clears READY and RXFULL. A write with bit 2 set empties the transmit queue and sets TXDONE and TXLOW.
- R11: With FIFOCTL bit 0 set, each byte sent on a tick goes into the receive queue when receive is enabled. `line_rx_valid` is then ignored and nothing appears on the line output.
- R12: `baud_div` equals 32 × m × (RATE + 1), where m is 1, 4, 16 or 64 for MODE bits 1:0 = 0 to 3. MODE keeps only bits 6:3 and 1:0 of a write.
- R13: A `brk_det` pulse sets BREAK. `irq_break` equals BREAK AND (CTRL bit 6 OR bit 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on DATA) |
| bus_dma | input | 1 | Access issued by the DMA engine |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data |
| tick | input | 1 | One pulse per frame time |
| brk_det | input | 1 | Break condition seen on the line |
| line_rx_valid | input | 1 | A byte from the line is offered on this tick |
| line_rx_byte | input | 8 | Byte from the line |
| line_tx_valid | output | 1 | A byte is sent toward the line |
| line_tx_byte | output | 8 | Byte toward the line |
| baud_div | output | 20 | Peripheral-clock divisor for the frame rate |
| irq_tx_empty | output | 1 | Transmit queue at or below its trigger |
| irq_rx_full | output | 1 | Receive queue at its trigger, or data ready |
| irq_rx_err | output | 1 | Receive overrun |
| irq_break | output | 1 | Break detected |

## Verification
A queue can be pushed and popped in the same cycle. On the transmit side this is a DATA write landing on the tick that drains a byte. On the receive side it is a DATA read landing on the tick that stores a loopback byte. A seeded random phase in loopback mixes writes, reads and ticks on every cycle, and a bench queue model tracks both directions. The model is judged on each byte read back, on the COUNT fields and on the overrun bit. Directed cases cover full queues, trigger boundaries and the two-tick idle timeout.

// File: rtl/serial_fifo_pkg.sv
package serial_fifo_pkg;

    localparam logic [2:0] A_MODE = 3'd0;
    localparam logic [2:0] A_RATE = 3'd1;
    localparam logic [2:0] A_CTRL = 3'd2;
    localparam logic [2:0] A_DATA = 3'd3;
    localparam logic [2:0] A_STAT = 3'd4;
    localparam logic [2:0] A_FCTL = 3'd5;
    localparam logic [2:0] A_CNT  = 3'd6;
    localparam logic [2:0] A_LINE = 3'd7;

    localparam int ST_READY  = 0;
    localparam int ST_RXFULL = 1;
    localparam int ST_BREAK  = 4;
    localparam int ST_TXLOW  = 5;
    localparam int ST_TXDONE = 6;

    localparam int CT_TXIE = 7;
    localparam int CT_RXIE = 6;
    localparam int CT_TXEN = 5;
    localparam int CT_RXEN = 4;
    localparam int CT_ERIE = 3;

    localparam int FC_LOOP  = 0;
    localparam int FC_RXRST = 1;
    localparam int FC_TXRST = 2;

    localparam logic [7:0] MODE_MASK = 8'h7B;
    localparam logic [7:0] CTRL_MASK = 8'hFA;
    localparam logic [7:0] FCTL_MASK = 8'hF1;
    localparam logic [7:0] STAT_INIT = 8'h60;

    typedef struct packed {
        logic [7:0] mode;
        logic [7:0] rate;
        logic [7:0] ctrl;
        logic [7:0] fctl;
        logic [7:0] status;
        logic       overrun;
        logic       rcvd_last;
        logic       tx_valid;
        logic [7:0] tx_byte;
    } regs_t;

    function automatic int rx_trig_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

    function automatic int tx_trig_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return 8;
            2'd1:    return 4;
            2'd2:    return 2;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/sf_byte_fifo.sv
module sf_byte_fifo #(
    parameter int  DEPTH = 16,
    parameter int  W     = 8,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [AW-1:0] rd_ptr;
        logic [AW-1:0] wr_ptr;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign dout    = mem[st_q.rd_ptr];
    assign count   = st_q.cnt;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wr_ptr = bump(st_q.wr_ptr);
            if (do_pop)  st_d.rd_ptr = bump(st_q.rd_ptr);
            st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wr_ptr] <= din;
    end

    // R1
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R1
    fifo_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> full);

endmodule

// File: rtl/sf_baud_div.sv
module sf_baud_div #(
    parameter int  RATE_W = 8,
    localparam int DIV_W  = RATE_W + 12
) (
    input  logic [1:0]        clk_sel,
    input  logic [RATE_W-1:0] rate,
    output logic [DIV_W-1:0]  divisor
);

    logic [DIV_W-1:0] base;

    always_comb begin
        base    = DIV_W'(rate) + DIV_W'(1);
        divisor = base << (5 + 2 * int'(clk_sel));
    end

endmodule

// File: rtl/serial_fifo_ctrl.sv
module serial_fifo_ctrl
    import serial_fifo_pkg::*;
#(
    parameter int  DEPTH  = 16,
    parameter int  RATE_W = 8,
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int DIV_W  = RATE_W + 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_dma,
    input  logic [2:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [15:0]      bus_rdata,
    input  logic             tick,
    input  logic             brk_det,
    input  logic             line_rx_valid,
    input  logic [7:0]       line_rx_byte,
    output logic             line_tx_valid,
    output logic [7:0]       line_tx_byte,
    output logic [DIV_W-1:0] baud_div,
    output logic             irq_tx_empty,
    output logic             irq_rx_full,
    output logic             irq_rx_err,
    output logic             irq_break
);

    regs_t st_d, st_q;

    logic          wr_mode, wr_rate, wr_ctrl, wr_data, wr_stat, wr_fctl, wr_line, rd_data;
    logic          tx_clr, rx_clr, tx_push, tx_pop, rx_push, rx_pop, rx_try, rx_ovf;
    logic          loop_on, rx_enabled;
    logic [7:0]    tx_head, rx_head, rx_in_byte;
    logic [CW-1:0] tx_cnt, rx_cnt, tx_cnt_n, rx_cnt_n, tx_trig, rx_trig;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0]    stat;

    assign wr_mode = bus_wr && bus_addr == A_MODE;
    assign wr_rate = bus_wr && bus_addr == A_RATE;
    assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
    assign wr_data = bus_wr && bus_addr == A_DATA;
    assign wr_stat = bus_wr && bus_addr == A_STAT;
    assign wr_fctl = bus_wr && bus_addr == A_FCTL;
    assign wr_line = bus_wr && bus_addr == A_LINE;
    assign rd_data = bus_rd && bus_addr == A_DATA;

    assign loop_on    = st_q.fctl[FC_LOOP];
    assign rx_enabled = st_q.ctrl[CT_RXEN] && !st_q.overrun;
    assign tx_trig    = CW'(tx_trig_of(st_q.fctl[5:4]));
    assign rx_trig    = CW'(rx_trig_of(st_q.fctl[7:6]));

    assign tx_clr  = wr_fctl && bus_wdata[FC_TXRST];
    assign rx_clr  = wr_fctl && bus_wdata[FC_RXRST];
    assign tx_push = wr_data && !tx_full;
    assign tx_pop  = tick && st_q.ctrl[CT_TXEN] && !tx_empty && !tx_clr;
    assign rx_pop  = rd_data && !rx_empty && !rx_clr;

    assign rx_in_byte = loop_on ? tx_head : line_rx_byte;
    assign rx_try     = (loop_on ? tx_pop : (tick && line_rx_valid)) && rx_enabled && !rx_clr;
    assign rx_push    = rx_try && !rx_full;
    assign rx_ovf     = rx_try && rx_full;

    assign tx_cnt_n = tx_clr ? '0 : tx_cnt + CW'(tx_push) - CW'(tx_pop);
    assign rx_cnt_n = rx_clr ? '0 : rx_cnt + CW'(rx_push) - CW'(rx_pop);

    sf_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push), .pop(tx_pop),
        .din(bus_wdata), .dout(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    sf_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .pop(rx_pop),
        .din(rx_in_byte), .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    sf_baud_div #(.RATE_W(RATE_W)) u_baud (
        .clk_sel(st_q.mode[1:0]), .rate(st_q.rate[RATE_W-1:0]), .divisor(baud_div)
    );

    always_comb begin
        st_d          = st_q;
        st_d.tx_valid = tx_pop && !loop_on;
        if (tx_pop && !loop_on) st_d.tx_byte = tx_head;
        if (wr_mode) st_d.mode = bus_wdata & MODE_MASK;
        if (wr_rate) st_d.rate = bus_wdata;
        if (wr_ctrl) st_d.ctrl = bus_wdata & CTRL_MASK;
        if (wr_fctl) st_d.fctl = bus_wdata & FCTL_MASK;

        stat = st_q.status;
        if (wr_stat) stat = stat & bus_wdata;
        if (tx_push && bus_dma) begin
            stat[ST_TXDONE] = 1'b0;
            if (tx_cnt_n > tx_trig) stat[ST_TXLOW] = 1'b0;
        end
        if (rx_pop && bus_dma && rx_cnt_n < rx_trig) begin
            stat[ST_RXFULL] = 1'b0;
            if (rx_cnt_n == '0) stat[ST_READY] = 1'b0;
        end
        if (tx_pop && tx_cnt_n <= tx_trig) begin
            stat[ST_TXLOW] = 1'b1;
            if (tx_cnt_n == '0) stat[ST_TXDONE] = 1'b1;
        end
        if (rx_push && rx_cnt_n >= rx_trig) stat[ST_RXFULL] = 1'b1;
        if (tick && !rx_push && !st_q.rcvd_last && rx_cnt_n != '0 && rx_cnt_n < rx_trig)
            stat[ST_READY] = 1'b1;
        if (brk_det) stat[ST_BREAK] = 1'b1;
        if (tx_clr) begin
            stat[ST_TXDONE] = 1'b1;
            stat[ST_TXLOW]  = 1'b1;
        end
        if (rx_clr) begin
            stat[ST_READY]  = 1'b0;
            stat[ST_RXFULL] = 1'b0;
        end
        st_d.status = stat;

        if (tick) st_d.rcvd_last = rx_push;
        if (rx_ovf)                        st_d.overrun = 1'b1;
        else if (wr_line && !bus_wdata[0]) st_d.overrun = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.status <= STAT_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MODE: bus_rdata[7:0] = st_q.mode;
            A_RATE: bus_rdata[7:0] = st_q.rate;
            A_CTRL: bus_rdata[7:0] = st_q.ctrl;
            A_DATA: bus_rdata[7:0] = rx_empty ? 8'h00 : rx_head;
            A_STAT: bus_rdata[7:0] = st_q.status;
            A_FCTL: bus_rdata[7:0] = st_q.fctl;
            A_CNT: begin
                bus_rdata[CW-1:0]  = rx_cnt;
                bus_rdata[8 +: CW] = tx_cnt;
            end
            default: bus_rdata[0] = st_q.overrun;
        endcase
    end

    assign line_tx_valid = st_q.tx_valid;
    assign line_tx_byte  = st_q.tx_byte;
    assign irq_tx_empty  = st_q.ctrl[CT_TXIE] && st_q.status[ST_TXLOW];
    assign irq_rx_full   = st_q.ctrl[CT_RXIE] && (st_q.status[ST_RXFULL] || st_q.status[ST_READY]);
    assign irq_rx_err    = (st_q.ctrl[CT_RXIE] || st_q.ctrl[CT_ERIE]) && st_q.overrun;
    assign irq_break     = (st_q.ctrl[CT_RXIE] || st_q.ctrl[CT_ERIE]) && st_q.status[ST_BREAK];

    // R5
    tx_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_tx_valid |-> $past(tick));

    // R2
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf |=> st_q.overrun);

    // R9
    ready_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.status[ST_READY]) |-> $past(tick));

    // R10
    rx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_FCTL && bus_wdata[FC_RXRST])
        |=> (rx_cnt == '0 && !st_q.status[ST_READY] && !st_q.status[ST_RXFULL]));

    // R10
    tx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_FCTL && bus_wdata[FC_TXRST])
        |=> (tx_cnt == '0 && st_q.status[ST_TXDONE] && st_q.status[ST_TXLOW]));

    // R13
    brk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_det |=> st_q.status[ST_BREAK]);

endmodule

// File: tb/test_serial_fifo_ctrl.sv
module test_serial_fifo_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 0, bus_rd = 0, bus_dma = 0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tick = 0, brk_det = 0, line_rx_valid = 0;
    logic [7:0]  line_rx_byte = '0;
    logic        line_tx_valid;
    logic [7:0]  line_tx_byte;
    logic [19:0] baud_div;
    logic        irq_tx_empty, irq_rx_full, irq_rx_err, irq_break;

    int n_checks = 0;
    int n_err    = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_fifo_ctrl i_serial_fifo_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_dma(bus_dma),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
        .brk_det(brk_det), .line_rx_valid(line_rx_valid), .line_rx_byte(line_rx_byte),
        .line_tx_valid(line_tx_valid), .line_tx_byte(line_tx_byte), .baud_div(baud_div),
        .irq_tx_empty(irq_tx_empty), .irq_rx_full(irq_rx_full), .irq_rx_err(irq_rx_err),
        .irq_break(irq_break)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic rd, input logic [2:0] a, input logic [7:0] wd,
                        input logic dma, input logic tk, input logic rxv, input logic [7:0] rxb,
                        input logic brk, output logic [15:0] rv);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd; bus_dma = dma;
        tick = tk; line_rx_valid = rxv; line_rx_byte = rxb; brk_det = brk;
        #1 rv = bus_rdata;
        @(posedge clk);
        #1;
        bus_wr = 0; bus_rd = 0; bus_dma = 0; tick = 0; line_rx_valid = 0; brk_det = 0;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d, input logic dma);
        logic [15:0] v;
        step(1, 0, a, d, dma, 0, 0, 8'h00, 0, v);
    endtask

    task automatic rd_reg(input logic [2:0] a, input logic dma, output logic [15:0] v);
        step(0, 1, a, 8'h00, dma, 0, 0, 8'h00, 0, v);
    endtask

    task automatic do_tick(input logic rxv, input logic [7:0] rxb);
        logic [15:0] v;
        step(0, 0, 3'd0, 8'h00, 0, 1, rxv, rxb, 0, v);
    endtask

    // expected divisor from R12
    function automatic int exp_div(input int sel, input int rate);
        int m;
        m = (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 16 : 64;
        return 32 * m * (rate + 1);
    endfunction

    function automatic int cnt_word(input int rxc, input int txc);
        return (txc << 8) | rxc;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  txq[$];
        logic [7:0]  rxq[$];
        bit          ovr;
        void'($urandom(32'd20251));

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd_reg(3'd4, 0, v); chk("R1 reset status", v, 16'h0060);
        rd_reg(3'd6, 0, v); chk("R1 reset count", v, 0);
        chk("R1 reset irqs", {irq_tx_empty, irq_rx_full, irq_rx_err, irq_break}, 0);

        // R12 divisor and mode mask
        wr_reg(3'd0, 8'hFF, 0);
        wr_reg(3'd1, 8'h0F, 0);
        rd_reg(3'd0, 0, v); chk("R12 mode mask", v, 16'h007B);
        chk("R12 divisor sel3", baud_div, exp_div(3, 15));
        wr_reg(3'd0, 8'h01, 0);
        wr_reg(3'd1, 8'h00, 0);
        chk("R12 divisor sel1", baud_div, exp_div(1, 0));

        // R6 CPU writes keep flags, DMA write clears
        wr_reg(3'd2, 8'h80, 0);
        chk("R5 irq_tx after reset", irq_tx_empty, 1);
        for (int i = 0; i < 9; i++) wr_reg(3'd3, 8'hA0 + 8'(i), 0);
        rd_reg(3'd4, 0, v); chk("R6 cpu write keeps flags", v, 16'h0060);
        rd_reg(3'd6, 0, v); chk("R1 tx count", v, cnt_word(0, 9));
        wr_reg(3'd3, 8'hA9, 1);
        rd_reg(3'd4, 0, v); chk("R6 dma write clears", v, 16'h0000);
        chk("R6 irq_tx low", irq_tx_empty, 0);

        // R5 transmit drain
        wr_reg(3'd2, 8'hA0, 0);
        do_tick(0, 0);
        chk("R5 first byte valid", line_tx_valid, 1);
        chk("R5 first byte", line_tx_byte, 8'hA0);
        rd_reg(3'd4, 0, v); chk("R5 above trigger", v, 16'h0000);
        do_tick(0, 0);
        chk("R5 second byte", line_tx_byte, 8'hA1);
        rd_reg(3'd4, 0, v); chk("R5 at trigger", v, 16'h0020);
        chk("R5 irq_tx", irq_tx_empty, 1);
        for (int i = 2; i < 10; i++) begin
            do_tick(0, 0);
            chk("R5 byte order", line_tx_byte, 8'hA0 + i);
        end
        do_tick(0, 0);
        chk("R5 no byte when empty", line_tx_valid, 0);
        rd_reg(3'd4, 0, v); chk("R5 txdone", v, 16'h0060);

        // R8 write-zero-to-clear
        wr_reg(3'd4, 8'hBF, 0);
        rd_reg(3'd4, 0, v); chk("R8 clear bit6", v, 16'h0020);
        wr_reg(3'd4, 8'hFF, 0);
        rd_reg(3'd4, 0, v); chk("R8 ones keep", v, 16'h0020);

        // R1 full transmit queue, R10 transmit reset
        wr_reg(3'd2, 8'h00, 0);
        for (int i = 0; i < 17; i++) wr_reg(3'd3, 8'(i), 0);
        rd_reg(3'd6, 0, v); chk("R1 tx full drop", v, cnt_word(0, 16));
        wr_reg(3'd4, 8'h00, 0);
        wr_reg(3'd5, 8'h04, 0);
        rd_reg(3'd4, 0, v); chk("R10 tx reset flags", v, 16'h0060);
        rd_reg(3'd6, 0, v); chk("R10 tx reset count", v, 0);

        // R3 transmit trigger 1
        wr_reg(3'd5, 8'h30, 0);
        wr_reg(3'd2, 8'h20, 0);
        wr_reg(3'd3, 8'h11, 1);
        rd_reg(3'd4, 0, v); chk("R3 tx trig1 count1", v, 16'h0020);
        wr_reg(3'd3, 8'h12, 1);
        rd_reg(3'd4, 0, v); chk("R3 tx trig1 count2", v, 16'h0000);
        do_tick(0, 0);
        rd_reg(3'd4, 0, v); chk("R3 tx trig1 reached", v, 16'h0020);
        do_tick(0, 0);
        rd_reg(3'd4, 0, v); chk("R5 drained", v, 16'h0060);

        // R3 / R4 receive trigger 4
        wr_reg(3'd5, 8'h40, 0);
        wr_reg(3'd2, 8'h50, 0);
        for (int i = 0; i < 3; i++) do_tick(1, 8'hB0 + 8'(i));
        rd_reg(3'd4, 0, v); chk("R4 below trigger", v & 16'h0003, 0);
        do_tick(1, 8'hB3);
        rd_reg(3'd4, 0, v); chk("R4 rxfull set", v & 16'h0003, 2);
        chk("R4 irq_rx", irq_rx_full, 1);
        rd_reg(3'd6, 0, v); chk("R1 rx count", v, cnt_word(4, 0));

        // R7 CPU read keeps, DMA read clears
        rd_reg(3'd3, 0, v); chk("R7 cpu read data", v, 16'h00B0);
        rd_reg(3'd4, 0, v); chk("R7 cpu read keeps", v & 16'h0003, 2);
        rd_reg(3'd3, 1, v); chk("R7 dma read data", v, 16'h00B1);
        rd_reg(3'd4, 0, v); chk("R7 dma read clears", v & 16'h0003, 0);
        chk("R7 irq_rx low", irq_rx_full, 0);

        // R9 ready after two quiet ticks
        do_tick(0, 0);
        rd_reg(3'd4, 0, v); chk("R9 one quiet tick", v & 16'h0001, 0);
        do_tick(0, 0);
        rd_reg(3'd4, 0, v); chk("R9 two quiet ticks", v & 16'h0001, 1);
        chk("R9 irq_rx", irq_rx_full, 1);
        rd_reg(3'd3, 1, v); chk("R7 data", v, 16'h00B2);
        rd_reg(3'd4, 0, v); chk("R7 ready kept", v & 16'h0001, 1);
        rd_reg(3'd3, 1, v); chk("R7 data last", v, 16'h00B3);
        rd_reg(3'd4, 0, v); chk("R7 ready cleared at empty", v & 16'h0001, 0);
        rd_reg(3'd3, 0, v); chk("R7 empty read", v, 0);

        // R2 overrun, R3 receive trigger 14
        wr_reg(3'd5, 8'hC2, 0);
        for (int i = 0; i < 13; i++) do_tick(1, 8'hC0 + 8'(i));
        rd_reg(3'd4, 0, v); chk("R3 rx trig14 below", v & 16'h0002, 0);
        do_tick(1, 8'hCD);
        rd_reg(3'd4, 0, v); chk("R3 rx trig14 reached", v & 16'h0002, 2);
        do_tick(1, 8'hCE);
        do_tick(1, 8'hCF);
        rd_reg(3'd7, 0, v); chk("R2 no overrun at 16", v, 0);
        do_tick(1, 8'hEE);
        rd_reg(3'd7, 0, v); chk("R2 overrun set", v, 1);
        chk("R2 irq_err", irq_rx_err, 1);
        do_tick(1, 8'hEF);
        rd_reg(3'd6, 0, v); chk("R2 count stays", v, cnt_word(16, 0));
        wr_reg(3'd7, 8'h00, 0);
        rd_reg(3'd7, 0, v); chk("R2 overrun cleared", v, 0);
        chk("R2 irq_err low", irq_rx_err, 0);
        for (int i = 0; i < 16; i++) begin
            rd_reg(3'd3, 0, v); chk("R2 kept bytes", v, 16'h00C0 + i);
        end

        // R13 break
        step(0, 0, 3'd0, 8'h00, 0, 0, 0, 8'h00, 1, v);
        rd_reg(3'd4, 0, v); chk("R13 break flag", v & 16'h0010, 16'h0010);
        chk("R13 irq_break", irq_break, 1);
        wr_reg(3'd4, 8'hEF, 0);
        chk("R13 break cleared", irq_break, 0);

        // R11 loopback
        wr_reg(3'd5, 8'h07, 0);
        wr_reg(3'd2, 8'h30, 0);
        wr_reg(3'd3, 8'hD0, 0);
        wr_reg(3'd3, 8'hD1, 0);
        do_tick(1, 8'h99);
        chk("R11 no line output", line_tx_valid, 0);
        do_tick(1, 8'h98);
        rd_reg(3'd6, 0, v); chk("R11 loop count", v, cnt_word(2, 0));
        rd_reg(3'd3, 0, v); chk("R11 loop byte0", v, 16'h00D0);
        rd_reg(3'd3, 0, v); chk("R11 loop byte1", v, 16'h00D1);

        // Random phase, loopback: concurrent push/pop on both queues (R1 R2 R11)
        wr_reg(3'd5, 8'h07, 0);
        ovr = 0;
        for (int c = 0; c < 600; c++) begin
            int          op;
            logic [7:0]  wd;
            logic [15:0] exp_rd;
            bit          txf, rxe, rxf, tk, wr, rd;
            op  = $urandom_range(0, 4);
            wd  = 8'($urandom);
            tk  = (op == 0 || op == 2 || op == 4);
            wr  = (op == 1 || op == 2);
            rd  = (op == 3 || op == 4);
            txf = (txq.size() == 16);
            rxe = (rxq.size() == 0);
            rxf = (rxq.size() == 16);
            exp_rd = rxe ? 16'h0 : {8'h00, rxq[0]};
            step(wr, rd, 3'd3, wd, 0, tk, 0, 8'h00, 0, v);
            if (rd) begin
                chk("R11 random read data", v, exp_rd);
                if (!rxe) void'(rxq.pop_front());
            end
            if (tk && txq.size() > 0) begin
                logic [7:0] b;
                b = txq.pop_front();
                if (!ovr) begin
                    if (rxf) ovr = 1;
                    else     rxq.push_back(b);
                end
            end
            if (wr && !txf) txq.push_back(wd);
            chk("R11 random no line output", line_tx_valid, 0);
            if (c % 40 == 39) begin
                rd_reg(3'd6, 0, v);
                chk("R1 random counts", v, cnt_word(rxq.size(), txq.size()));
                rd_reg(3'd7, 0, v);
                chk("R2 random overrun", v, int'(ovr));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule